// File: doc/BRIEF.md
# Ethernet Frame Status Classifier

This block monitors a 32-bit valid/ready packet stream that carries one Ethernet frame per packet, from the destination address through the FCS. A beat is taken only when valid and ready are both high. The block does not drive ready and does not change the stream. As beats pass, it counts bytes, keeps the first six header words, and reads the address, tag and type fields. On the beat that closes the frame, it presents a 40-bit status word and a 7-bit error vector, qualified by a status strobe.

The status word carries the payload length, the total frame length and eight class flags. The flags cover broadcast, multicast or unicast destination, one or two VLAN tags, MAC control frames, and the pause and priority-flow-control opcodes. The error vector flags runt and oversized frames, a mismatch between a length-style type field and the real payload, a source that ran dry in mid-frame, and errors the client marked on the stream. The status leaves through combinational paths on the closing beat, so a consumer can latch it together with that beat.

Top module: `frame_status_classifier`

## Requirements
- R1: The first byte of a beat is `s_data[31:24]`, and later bytes follow in falling bit order. On the closing beat, `s_empty` gives the number of invalid trailing bytes (0 to 3). `st_word[31:16]` holds the frame length in bytes: 4 per accepted beat, minus `s_empty` on the last beat.
- R2: Exactly one of three flags is set. `st_word[36]` marks an all-ones destination address. Otherwise `st_word[37]` marks a destination whose first byte has bit 0 set. Otherwise `st_word[38]` marks unicast.
- R3: A type of 0x8100 or 0x88A8 at bytes 12-13 marks a tag and sets `st_word[33]`. A type of 0x8100 at bytes 16-17 after that marks a second tag. `st_word[32]` is set when the outer type is 0x88A8 or when there are two tags. The effective type is read 4 bytes further on for each tag.
- R4: An effective type of 0x8808 sets `st_word[34]`. Within such frames, the 16-bit opcode that follows the type sets `st_word[35]` when it is 0x0001 and `st_word[39]` when it is 0x0101.
- R5: `st_word[15:0]` equals the frame length minus 18, minus 4 per tag. It is 0 when that difference would be negative.
- R6: `st_error[0]` is set for frames shorter than 64 bytes. `st_error[1]` is set for frames longer than MAX_FRAME, which defaults to 1518 bytes.
- R7: When the effective type is below 0x0600, `st_error[2]` is set if the type differs from the payload length. A frame of exactly 64 bytes whose type is smaller than the payload length counts as padded and is not flagged.
- R8: `st_error[4]` is set when `s_valid` is low in any cycle after the start beat and before the closing beat.
- R9: `st_error[5]` is set when `s_error` is high on any accepted beat of the frame. Beats offered while `s_ready` is low contribute nothing.
- R10: `st_valid` is high only in a cycle where a beat with `s_eop` is accepted. A closing beat that is held off by low `s_ready` gives no strobe. `st_error[3]` and `st_error[6]` always read 0.
- R11: After reset, and after each closing beat, no field of an earlier frame affects the status of the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Stream beat valid |
| s_ready | input | 1 | Stream beat ready, observed only |
| s_sop | input | 1 | First beat of frame |
| s_eop | input | 1 | Last beat of frame |
| s_empty | input | 2 | Invalid trailing bytes on last beat |
| s_error | input | 1 | Client error mark |
| s_data | input | 32 | Stream data, first byte in top bits |
| st_valid | output | 1 | Status strobe |
| st_word | output | 40 | Lengths and class flags |
| st_error | output | 7 | Error vector |

## Verification
Every result is due in the same cycle as the accepted closing beat. The bench drives each beat on the falling edge and reads `st_valid`, `st_word` and `st_error` one nanosecond later, before the next rising edge, and it keeps the values from the cycle in which the strobe shows. For stalled closing beats, it also counts strobes seen while ready is low, and that count must be zero. Frame state built up over earlier beats is stored at rising edges. A check on the next frame therefore shows whether anything carried over from the earlier one.

// File: rtl/fsc_pkg.sv
`timescale 1ns/1ps
package fsc_pkg;
   localparam logic [15:0] TPID_CTAG      = 16'h8100;
   localparam logic [15:0] TPID_STAG      = 16'h88A8;
   localparam logic [15:0] ETYPE_MACCTRL  = 16'h8808;
   localparam logic [15:0] OPC_PAUSE      = 16'h0001;
   localparam logic [15:0] OPC_PFC        = 16'h0101;
   localparam logic [15:0] LEN_TYPE_LIMIT = 16'h0600;
   // header (14) plus FCS (4); each tag adds TAG_BYTES
   localparam int unsigned BASE_OVERHEAD  = 18;
   localparam int unsigned TAG_BYTES      = 4;
   localparam int unsigned BEAT_BYTES     = 4;
   localparam int unsigned MIN_HDR_WORDS  = 6;

   typedef struct packed {
      logic pfc;    // 39
      logic ucast;  // 38
      logic mcast;  // 37
      logic bcast;  // 36
      logic pause;  // 35
      logic ctrl;   // 34
      logic vlan;   // 33
      logic svlan;  // 32
   } fsc_flags_t;
endpackage

// File: rtl/fsc_beat_tracker.sv
`timescale 1ns/1ps
module fsc_beat_tracker #(
   parameter int unsigned LEN_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             valid,
   input  logic             fire,
   input  logic             sop,
   input  logic             eop,
   input  logic [1:0]       empty,
   input  logic             error,
   output logic [LEN_W-3:0] beat_idx,
   output logic [LEN_W-1:0] byte_len,
   output logic             client_err,
   output logic             underflow
);
   localparam int unsigned IDX_W = LEN_W - 2;

   logic             in_frame_q;
   logic [IDX_W-1:0] cnt_q;
   logic             err_acc_q;
   logic             udf_acc_q;
   logic [IDX_W-1:0] idx_next;

   // a start beat always restarts the word index and the sticky flags
   assign beat_idx   = sop ? '0 : cnt_q;
   assign idx_next   = (&beat_idx) ? beat_idx : beat_idx + 1'b1;
   assign byte_len   = {beat_idx, 2'b00} + LEN_W'(3'd4 - {1'b0, empty});
   assign client_err = (sop ? 1'b0 : err_acc_q) | (fire & error);
   assign underflow  = sop ? 1'b0 : udf_acc_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         in_frame_q <= 1'b0;
         cnt_q      <= '0;
         err_acc_q  <= 1'b0;
         udf_acc_q  <= 1'b0;
      end else if (fire) begin
         if (eop) begin
            in_frame_q <= 1'b0;
            cnt_q      <= '0;
            err_acc_q  <= 1'b0;
            udf_acc_q  <= 1'b0;
         end else begin
            in_frame_q <= 1'b1;
            cnt_q      <= idx_next;
            err_acc_q  <= client_err;
            udf_acc_q  <= underflow;
         end
      end else if (in_frame_q && !valid) begin
         udf_acc_q <= 1'b1;
      end
   end
endmodule

// File: rtl/fsc_header_capture.sv
`timescale 1ns/1ps
module fsc_header_capture #(
   parameter int unsigned HDR_WORDS = 6,
   parameter int unsigned IDX_W     = 14,
   parameter int unsigned DATA_W    = 32
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             fire,
   input  logic                             sop,
   input  logic                             eop,
   input  logic [IDX_W-1:0]                 beat_idx,
   input  logic [DATA_W-1:0]                data,
   output logic [HDR_WORDS-1:0][DATA_W-1:0] hdr_view
);
   for (genvar k = 0; k < HDR_WORDS; k++) begin : g_word
      logic [DATA_W-1:0] word_q;
      logic              hit;

      assign hit = fire && (beat_idx == IDX_W'(k));

      // the live beat is visible at once; a new frame hides stale words
      assign hdr_view[k] = hit          ? data :
                           (fire && sop) ? '0   : word_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            word_q <= '0;
         end else if (fire) begin
            if (eop)      word_q <= '0;
            else if (hit) word_q <= data;
            else if (sop) word_q <= '0;
         end
      end
   end
endmodule

// File: rtl/fsc_classifier.sv
`timescale 1ns/1ps
module fsc_classifier
   import fsc_pkg::*;
#(
   parameter int unsigned LEN_W        = 16,
   parameter int unsigned HDR_WORDS    = 6,
   parameter int unsigned MIN_FRAME    = 64,
   parameter int unsigned MAX_FRAME    = 1518,
   parameter bit          LENGTH_CHECK = 1'b1
) (
   input  logic [HDR_WORDS-1:0][31:0] hdr_view,
   input  logic [LEN_W-1:0]           byte_len,
   output fsc_flags_t                 flags,
   output logic [LEN_W-1:0]           payload_len,
   output logic                       err_short,
   output logic                       err_long,
   output logic                       err_len
);
   logic [15:0]      type_at12, type_at16, type_at20;
   logic [15:0]      opc_at14, opc_at18, opc_at22;
   logic             tag_one, tag_two;
   logic [1:0]       ntags;
   logic [15:0]      eff_type, eff_opc;
   logic [LEN_W-1:0] overhead;
   logic             unused_hdr;

   assign type_at12 = hdr_view[3][31:16];
   assign opc_at14  = hdr_view[3][15:0];
   assign type_at16 = hdr_view[4][31:16];
   assign opc_at18  = hdr_view[4][15:0];
   assign type_at20 = hdr_view[5][31:16];
   assign opc_at22  = hdr_view[5][15:0];
   assign unused_hdr = ^hdr_view;

   assign tag_one = (type_at12 == TPID_CTAG) || (type_at12 == TPID_STAG);
   assign tag_two = tag_one && (type_at16 == TPID_CTAG);
   assign ntags   = tag_two ? 2'd2 : (tag_one ? 2'd1 : 2'd0);

   always_comb begin
      unique case (ntags)
         2'd2:    begin eff_type = type_at20; eff_opc = opc_at22; end
         2'd1:    begin eff_type = type_at16; eff_opc = opc_at18; end
         default: begin eff_type = type_at12; eff_opc = opc_at14; end
      endcase
   end

   // destination address class
   always_comb begin
      flags       = '0;
      flags.bcast = (&hdr_view[0]) && (&hdr_view[1][31:16]);
      flags.mcast = !flags.bcast && hdr_view[0][24];
      flags.ucast = !flags.bcast && !hdr_view[0][24];
      flags.vlan  = tag_one;
      flags.svlan = tag_two || (type_at12 == TPID_STAG);
      flags.ctrl  = (eff_type == ETYPE_MACCTRL);
      flags.pause = flags.ctrl && (eff_opc == OPC_PAUSE);
      flags.pfc   = flags.ctrl && (eff_opc == OPC_PFC);
   end

   assign overhead    = LEN_W'(BASE_OVERHEAD) + LEN_W'({ntags, 2'b00});
   assign payload_len = (byte_len > overhead) ? byte_len - overhead : '0;
   assign err_short   = byte_len < LEN_W'(MIN_FRAME);
   assign err_long    = byte_len > LEN_W'(MAX_FRAME);

   if (LENGTH_CHECK) begin : g_len_chk
      logic [LEN_W-1:0] field_len;
      logic             is_length;
      logic             padded;
      assign field_len = LEN_W'(eff_type);
      assign is_length = eff_type < LEN_TYPE_LIMIT;
      assign padded    = (byte_len == LEN_W'(MIN_FRAME)) && (field_len < payload_len);
      assign err_len   = is_length && (field_len != payload_len) && !padded;
   end else begin : g_no_len_chk
      assign err_len = 1'b0;
   end
endmodule

// File: rtl/frame_status_classifier.sv
`timescale 1ns/1ps
module frame_status_classifier
   import fsc_pkg::*;
#(
   parameter int unsigned LEN_W        = 16,
   parameter int unsigned HDR_WORDS    = 6,
   parameter int unsigned MIN_FRAME    = 64,
   parameter int unsigned MAX_FRAME    = 1518,
   parameter bit          LENGTH_CHECK = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        s_valid,
   input  logic        s_ready,
   input  logic        s_sop,
   input  logic        s_eop,
   input  logic [1:0]  s_empty,
   input  logic        s_error,
   input  logic [31:0] s_data,
   output logic        st_valid,
   output logic [39:0] st_word,
   output logic [6:0]  st_error
);
   localparam int unsigned IDX_W = LEN_W - 2;

   if (LEN_W < 16) begin : g_bad_len_w
      $error("LEN_W must be at least 16");
   end
   if (HDR_WORDS < MIN_HDR_WORDS) begin : g_bad_hdr_words
      $error("HDR_WORDS must cover bytes 0 to 23");
   end
   if (MAX_FRAME <= MIN_FRAME) begin : g_bad_limits
      $error("MAX_FRAME must exceed MIN_FRAME");
   end
   if (MAX_FRAME >= (1 << LEN_W)) begin : g_bad_max
      $error("MAX_FRAME must fit in LEN_W bits");
   end

   logic                          fire;
   logic [IDX_W-1:0]              beat_idx;
   logic [LEN_W-1:0]              byte_len;
   logic                          client_err;
   logic                          underflow;
   logic [HDR_WORDS-1:0][31:0]    hdr_view;
   fsc_flags_t                    flags;
   logic [LEN_W-1:0]              payload_len;
   logic                          err_short, err_long, err_len;

   assign fire = s_valid & s_ready;

   fsc_beat_tracker #(.LEN_W(LEN_W)) u_track (
      .clk        (clk),
      .rst_n      (rst_n),
      .valid      (s_valid),
      .fire       (fire),
      .sop        (s_sop),
      .eop        (s_eop),
      .empty      (s_empty),
      .error      (s_error),
      .beat_idx   (beat_idx),
      .byte_len   (byte_len),
      .client_err (client_err),
      .underflow  (underflow)
   );

   fsc_header_capture #(
      .HDR_WORDS (HDR_WORDS),
      .IDX_W     (IDX_W),
      .DATA_W    (32)
   ) u_hdr (
      .clk      (clk),
      .rst_n    (rst_n),
      .fire     (fire),
      .sop      (s_sop),
      .eop      (s_eop),
      .beat_idx (beat_idx),
      .data     (s_data),
      .hdr_view (hdr_view)
   );

   fsc_classifier #(
      .LEN_W        (LEN_W),
      .HDR_WORDS    (HDR_WORDS),
      .MIN_FRAME    (MIN_FRAME),
      .MAX_FRAME    (MAX_FRAME),
      .LENGTH_CHECK (LENGTH_CHECK)
   ) u_cls (
      .hdr_view    (hdr_view),
      .byte_len    (byte_len),
      .flags       (flags),
      .payload_len (payload_len),
      .err_short   (err_short),
      .err_long    (err_long),
      .err_len     (err_len)
   );

   assign st_valid = fire & s_eop;
   assign st_word  = {flags, byte_len[15:0], payload_len[15:0]};
   assign st_error = {1'b0, client_err, underflow, 1'b0, err_len, err_long, err_short};
endmodule

// File: rtl/fsc_checker.sv
`timescale 1ns/1ps
module fsc_checker (
   input logic        clk,
   input logic        rst_n,
   input logic        s_valid,
   input logic        s_ready,
   input logic        s_sop,
   input logic        s_eop,
   input logic        st_valid,
   input logic [39:0] st_word,
   input logic [6:0]  st_error
);
   logic unused_err;
   assign unused_err = st_error[2] ^ st_error[5];

   assert_strobe_on_eop_R10: assert property (@(posedge clk) disable iff (!rst_n)
      st_valid |-> (s_valid && s_ready && s_eop));

   assert_unused_bits_R10: assert property (@(posedge clk) disable iff (!rst_n)
      st_valid |-> (!st_error[3] && !st_error[6]));

   assert_addr_class_R2: assert property (@(posedge clk) disable iff (!rst_n)
      st_valid |-> ($countones(st_word[38:36]) == 1));

   assert_ctrl_opcode_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (st_valid && (st_word[35] || st_word[39])) |-> st_word[34]);

   assert_stacked_tag_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (st_valid && st_word[32]) |-> st_word[33]);

   assert_size_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
      st_valid |-> !(st_error[0] && st_error[1]));

   assert_payload_le_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
      st_valid |-> (st_word[15:0] <= st_word[31:16]));

   assert_single_beat_no_udf_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (st_valid && s_sop) |-> !st_error[4]);
endmodule

bind frame_status_classifier fsc_checker u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .s_valid  (s_valid),
   .s_ready  (s_ready),
   .s_sop    (s_sop),
   .s_eop    (s_eop),
   .st_valid (st_valid),
   .st_word  (st_word),
   .st_error (st_error)
);

// File: tb/frame_status_classifier_tb.sv
`timescale 1ns/1ps
module frame_status_classifier_tb;
   typedef struct packed {
      logic [47:0] da;
      logic [15:0] t0, t1, t2, t3, t4, t5;
      logic [15:0] len;
      logic [39:0] word;
      logic [6:0]  err;
   } vec_t;

   localparam int NVEC = 17;
   localparam vec_t VECS [0:NVEC-1] = '{
      '{48'h001122334455, 16'h0800, 16'h4500, 16'h0, 16'h0, 16'h0, 16'h0, 16'd64,   {8'h40, 16'd64,   16'd46},   7'h00},
      '{48'hFFFFFFFFFFFF, 16'h0806, 16'h0001, 16'h0, 16'h0, 16'h0, 16'h0, 16'd60,   {8'h10, 16'd60,   16'd42},   7'h01},
      '{48'h01005E000001, 16'h8100, 16'h0005, 16'h0800, 16'h0, 16'h0, 16'h0, 16'd100, {8'h22, 16'd100, 16'd78}, 7'h00},
      '{48'h020000000001, 16'h88A8, 16'h0064, 16'h8100, 16'h0007, 16'h0800, 16'h0, 16'd128, {8'h43, 16'd128, 16'd102}, 7'h00},
      '{48'h333300000001, 16'h8100, 16'h0001, 16'h8100, 16'h0002, 16'h86DD, 16'h0, 16'd72, {8'h23, 16'd72, 16'd46}, 7'h00},
      '{48'h0180C2000001, 16'h8808, 16'h0001, 16'h0, 16'h0, 16'h0, 16'h0, 16'd64,   {8'h2C, 16'd64,   16'd46},   7'h00},
      '{48'h0180C2000001, 16'h8808, 16'h0101, 16'h0, 16'h0, 16'h0, 16'h0, 16'd64,   {8'hA4, 16'd64,   16'd46},   7'h00},
      '{48'h0180C2000001, 16'h8808, 16'h0002, 16'h0, 16'h0, 16'h0, 16'h0, 16'd64,   {8'h24, 16'd64,   16'd46},   7'h00},
      '{48'h001122334455, 16'h0036, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'd72,     {8'h40, 16'd72,   16'd54},   7'h00},
      '{48'h001122334455, 16'h0030, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'd72,     {8'h40, 16'd72,   16'd54},   7'h04},
      '{48'h001122334455, 16'h0010, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'd64,     {8'h40, 16'd64,   16'd46},   7'h00},
      '{48'h001122334455, 16'h0040, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'd64,     {8'h40, 16'd64,   16'd46},   7'h04},
      '{48'h001122334455, 16'h0800, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'd1522,   {8'h40, 16'd1522, 16'd1504}, 7'h02},
      '{48'h001122334455, 16'h0800, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'd1518,   {8'h40, 16'd1518, 16'd1500}, 7'h00},
      '{48'h001122334455, 16'h0800, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'd63,     {8'h40, 16'd63,   16'd45},   7'h01},
      '{48'h001122334455, 16'h0800, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'd65,     {8'h40, 16'd65,   16'd47},   7'h00},
      '{48'h001122334455, 16'h8100, 16'h0000, 16'h002E, 16'h0, 16'h0, 16'h0, 16'd68, {8'h42, 16'd68, 16'd46},  7'h00}
   };
   localparam string VTAG [0:NVEC-1] = '{
      "R1 R2 unicast", "R2 R6 broadcast runt", "R3 single tag", "R3 outer 88A8",
      "R3 two 8100 tags", "R4 pause", "R4 PFC", "R4 other opcode", "R7 length ok",
      "R7 length bad", "R7 padded", "R7 field above payload", "R6 oversize",
      "R6 max size", "R1 R6 empty=1", "R1 empty=3", "R5 R7 tagged length"
   };

   logic        clk = 1'b0;
   logic        rst_n;
   logic        s_valid, s_ready, s_sop, s_eop, s_error;
   logic [1:0]  s_empty;
   logic [31:0] s_data;
   logic        st_valid;
   logic [39:0] st_word;
   logic [6:0]  st_error;

   int checks = 0;
   int errors = 0;
   logic [7:0] fb [0:2047];

   always #2.5 clk = ~clk;

   frame_status_classifier u_dut (
      .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
      .s_sop(s_sop), .s_eop(s_eop), .s_empty(s_empty), .s_error(s_error),
      .s_data(s_data), .st_valid(st_valid), .st_word(st_word), .st_error(st_error)
   );

   task automatic check(input string what, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", what, act, exp);
      end
   endtask

   task automatic idle();
      @(negedge clk);
      s_valid = 1'b0; s_ready = 1'b1; s_sop = 1'b0; s_eop = 1'b0;
      s_error = 1'b0; s_empty = 2'd0; s_data = '0;
   endtask

   task automatic build(input vec_t v);
      for (int i = 0; i < 2048; i++) fb[i] = 8'(i) ^ 8'h5C;
      for (int i = 0; i < 6; i++) fb[i] = v.da[47-8*i -: 8];
      for (int i = 6; i < 12; i++) fb[i] = 8'hA0 + 8'(i);
      {fb[12], fb[13]} = v.t0; {fb[14], fb[15]} = v.t1;
      {fb[16], fb[17]} = v.t2; {fb[18], fb[19]} = v.t3;
      {fb[20], fb[21]} = v.t4; {fb[22], fb[23]} = v.t5;
   endtask

   task automatic send(input vec_t v, input int gap_at, input int err_at, input int stall_at,
                       output logic [39:0] w, output logic [6:0] e,
                       output int strobes, output int stall_strobes);
      int nb;
      int len;
      len = int'(v.len);
      nb = (len + 3) / 4;
      strobes = 0; stall_strobes = 0; w = '0; e = '0;
      build(v);
      for (int b = 0; b < nb; b++) begin
         logic [31:0] d;
         d = {fb[4*b], fb[4*b+1], fb[4*b+2], fb[4*b+3]};
         if (b == gap_at) begin
            @(negedge clk);
            s_valid = 1'b0; s_ready = 1'b1; s_sop = 1'b0; s_eop = 1'b0; s_error = 1'b0;
            #1;
            if (st_valid) strobes++;
         end
         if (b == stall_at) begin
            for (int s = 0; s < 2; s++) begin
               @(negedge clk);
               s_valid = 1'b1; s_ready = 1'b0; s_sop = (b == 0); s_eop = (b == nb-1);
               s_empty = (b == nb-1) ? 2'(nb*4 - len) : 2'd0;
               s_error = 1'b1; s_data = d;
               #1;
               if (st_valid) stall_strobes++;
            end
         end
         @(negedge clk);
         s_valid = 1'b1; s_ready = 1'b1; s_sop = (b == 0); s_eop = (b == nb-1);
         s_empty = (b == nb-1) ? 2'(nb*4 - len) : 2'd0;
         s_error = (b == err_at); s_data = d;
         #1;
         if (st_valid) begin
            strobes++; w = st_word; e = st_error;
         end
      end
      idle();
   endtask

   initial begin
      #(5.0 * 150000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [39:0] w;
      logic [6:0]  e;
      int          ns, nss;
      vec_t        v;

      rst_n = 1'b0;
      s_valid = 1'b0; s_ready = 1'b1; s_sop = 1'b0; s_eop = 1'b0;
      s_error = 1'b0; s_empty = 2'd0; s_data = '0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      #1;
      check("R11 reset strobe low", 64'(st_valid), 64'd0);

      // table walk
      for (int i = 0; i < NVEC; i++) begin
         send(VECS[i], -1, -1, -1, w, e, ns, nss);
         check({VTAG[i], " strobes"}, 64'(ns), 64'd1);
         check({VTAG[i], " word"}, 64'(w), 64'(VECS[i].word));
         check({VTAG[i], " error"}, 64'(e), 64'(VECS[i].err));
      end

      // R9 client error on an accepted middle beat
      send(VECS[0], -1, 5, -1, w, e, ns, nss);
      check("R9 client error bit", 64'(e), 64'h20);
      check("R9 word unaffected", 64'(w), 64'(VECS[0].word));

      // R11 no carry-over to the next frame
      send(VECS[0], -1, -1, -1, w, e, ns, nss);
      check("R11 clean after error", 64'(e), 64'h00);

      // R8 source gap in mid frame
      send(VECS[2], 3, -1, -1, w, e, ns, nss);
      check("R8 underflow bit", 64'(e), 64'h10);
      check("R8 word unaffected", 64'(w), 64'(VECS[2].word));

      // R9 stalled beat with error flag high is ignored
      send(VECS[0], -1, -1, 4, w, e, ns, nss);
      check("R9 stall error ignored", 64'(e), 64'h00);
      check("R9 stall word", 64'(w), 64'(VECS[0].word));

      // R10 closing beat held off
      send(VECS[0], -1, -1, 15, w, e, ns, nss);
      check("R10 no strobe while stalled", 64'(nss), 64'd0);
      check("R10 one strobe", 64'(ns), 64'd1);
      check("R10 unused bits zero", 64'({e[6], e[3]}), 64'd0);

      // R5 single-beat frame, payload floors at zero
      v = '{48'hFFFFFFFF1234, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'd4,
            {8'h20, 16'd4, 16'd0}, 7'h01};
      send(v, -1, -1, -1, w, e, ns, nss);
      check("R5 single beat word", 64'(w), 64'(v.word));
      check("R5 single beat error", 64'(e), 64'(v.err));

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule